// File: doc/BRIEF.md
# Address-Folded SECDED Memory Wrapper

This block wraps a single-port synchronous RAM and protects every stored word with a seven-bit Hsiao code. The code corrects one bit and detects two. The check bits are generated from the write data and from the write address together. The address bits are never stored, but they take part in the code. A read that lands on a row written for a different address therefore gives a nonzero syndrome and is reported as an error. A read returns corrected data one cycle after the request, along with a valid strobe and two flags: one for a repaired single error and one for an uncorrectable error. The array itself is never rewritten because of an error.

Before an unwritten word can be read safely, it must carry valid check bits. After reset, an optional sequencer writes zero data with matching check bits to every row, in ascending address order. A busy output stays high while it runs, and port accesses are dropped during that time. An instance whose software fills the memory itself can switch the sequencer off with a parameter. A test input XORs a mask into the codeword on port writes, so that bit faults can be injected deliberately.

Top module: `secded_ram`

## Requirements
- R1: A write followed by a read of the same address returns the written data with `err_corr` and `err_uncorr` low. Data and flags are zero whenever `rvalid` is low.
- R2: Codeword layout and H-matrix. The stored word holds data in bits [DATA_W-1:0] and check bits in [DATA_W+6:DATA_W]. The H-matrix columns are assigned in this order: all weight-3 seven-bit vectors in ascending numeric order, then the weight-5 vectors, then the weight-7 vector. Data bit i takes column i, and address bit j takes column DATA_W+j. Check bit k has the unit vector for bit k. Each check bit is the XOR of the data and address bits whose column has that bit set.
- R3: A single flipped data bit is corrected on read, with `err_corr`=1 and `err_uncorr`=0.
- R4: A single flipped check bit returns the original data, with `err_corr`=1 and `err_uncorr`=0.
- R5: Two flipped bits give `err_uncorr`=1 and `err_corr`=0. The two flags are never high together.
- R6: A syndrome equal to an address column is reported as uncorrectable. This is what a read of a row that was encoded for another address produces.
- R7: A detected error never causes a write to the array. Reading the same faulty word again reports the same flag again.
- R8: With INIT_EN=1, `busy` is high in reset and for exactly DEPTH cycles after reset is released, then stays low. Every location then reads as zero with no flags.
- R9: While `busy` is high, `req` is ignored: reads give no `rvalid` and writes leave the array untouched.
- R10: `rvalid` is high exactly in the cycle after an accepted read (`req`=1, `we`=0, `busy`=0), and never after a write.
- R11: On an accepted write, `inj_mask` is XORed into the stored codeword, using the bit positions given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| inj_mask | input | DATA_W+7 | Fault mask XORed into the stored codeword on writes (test only) |
| busy | output | 1 | Initialization in progress |
| rvalid | output | 1 | Read result valid |
| rdata | output | DATA_W | Corrected read data |
| err_corr | output | 1 | Single error was corrected |
| err_uncorr | output | 1 | Uncorrectable error detected |

## Verification
A wrong column in the encoder or decoder appears at the ports on the first read after an injected fault. The symptom is either a flipped bit in `rdata` or the wrong flag, seen in the same cycle as `rvalid`. A stuck or miscounted init pointer shows up as a `busy` length different from DEPTH. It also shows up as a row that reads back nonzero or flagged once initialization ends. A wrongly gated accept path shows up either as an `rvalid` in the cycle after a request made during initialization, or as a write issued during initialization that survives into a later read.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int CHK_W   = 7;
    localparam int MAX_COL = 57;

    // k-th H-matrix column: weight-3 vectors ascending, then weight-5, then weight-7
    function automatic logic [CHK_W-1:0] hcol(input int k);
        int n;
        logic [CHK_W-1:0] r;
        n = 0;
        r = '0;
        for (int w = 3; w <= CHK_W; w += 2) begin
            for (int v = 0; v < (1 << CHK_W); v++) begin
                if ($countones(CHK_W'(v)) == w) begin
                    if (n == k) r = CHK_W'(v);
                    n++;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] addr,
    output logic [CHK_W-1:0]  chk
);
    localparam int N_IN = DATA_W + ADDR_W;

    logic [N_IN-1:0]  in_bits;
    logic [CHK_W-1:0] contrib [N_IN];

    assign in_bits = {addr, data};

    for (genvar i = 0; i < N_IN; i++) begin : g_col
        localparam logic [CHK_W-1:0] COL = hcol(i);
        assign contrib[i] = in_bits[i] ? COL : '0;
    end

    always_comb begin
        chk = '0;
        for (int i = 0; i < N_IN; i++) begin
            chk = chk ^ contrib[i];
        end
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    localparam int CW_W  = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]   cw,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data_o,
    output logic              corr,
    output logic              uncorr
);
    logic [CHK_W-1:0]  recalc;
    logic [CHK_W-1:0]  syn;
    logic [DATA_W-1:0] match;
    logic              hit;

    secded_enc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_enc (
        .data (cw[DATA_W-1:0]),
        .addr (addr),
        .chk  (recalc)
    );

    assign syn = recalc ^ cw[CW_W-1:DATA_W];

    // Only data columns flip a bit; address columns never match here
    for (genvar i = 0; i < DATA_W; i++) begin : g_match
        localparam logic [CHK_W-1:0] COL = hcol(i);
        assign match[i] = (syn == COL);
    end

    always_comb begin
        hit    = (|match) || $onehot(syn);
        data_o = cw[DATA_W-1:0] ^ match;
        corr   = (syn != '0) && hit;
        uncorr = (syn != '0) && !hit;
    end

endmodule

// File: rtl/secded_init.sv
module secded_init #(
    parameter int ADDR_W  = 10,
    parameter int DEPTH   = 1 << ADDR_W,
    parameter bit ENABLE  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] ptr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy) begin
            if (seq_q.ptr == LAST) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.ptr = seq_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.busy <= ENABLE;
            seq_q.ptr  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = seq_q.busy;
    assign wr_en   = seq_q.busy;
    assign wr_addr = seq_q.ptr;

endmodule

// File: rtl/secded_ram.sv
module secded_ram
    import secded_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 10,
    parameter int DEPTH   = 1 << ADDR_W,
    parameter bit INIT_EN = 1'b1,
    localparam int CW_W   = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CW_W-1:0]   inj_mask,
    output logic              busy,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              err_corr,
    output logic              err_uncorr
);
    typedef struct packed {
        logic              rvld;
        logic [ADDR_W-1:0] raddr;
    } rd_t;

    rd_t st_d, st_q;

    logic              init_wr;
    logic [ADDR_W-1:0] init_addr;
    logic              acc_ok, rd_en, ext_wr, wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] enc_data;
    logic [CHK_W-1:0]  enc_chk;
    logic [CW_W-1:0]   wr_cw;
    logic [CW_W-1:0]   mem [DEPTH];
    logic [CW_W-1:0]   rcw_q;
    logic [DATA_W-1:0] dec_data;
    logic              dec_corr, dec_uncorr;

    secded_init #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ENABLE(INIT_EN)) u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .wr_en   (init_wr),
        .wr_addr (init_addr)
    );

    always_comb begin
        acc_ok   = req && !busy;
        rd_en    = acc_ok && !we;
        ext_wr   = acc_ok && we;
        wr_en    = init_wr || ext_wr;
        wr_addr  = init_wr ? init_addr : addr;
        enc_data = init_wr ? '0 : wdata;
    end

    secded_enc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_enc (
        .data (enc_data),
        .addr (wr_addr),
        .chk  (enc_chk)
    );

    assign wr_cw = {enc_chk, enc_data} ^ (init_wr ? '0 : inj_mask);

    // Array and read register: no reset, no write-back path on error
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_cw;
        end
        if (rd_en) begin
            rcw_q <= mem[addr];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.rvld = rd_en;
        if (rd_en) begin
            st_d.raddr = addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    secded_dec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .cw     (rcw_q),
        .addr   (st_q.raddr),
        .data_o (dec_data),
        .corr   (dec_corr),
        .uncorr (dec_uncorr)
    );

    assign rvalid     = st_q.rvld;
    assign rdata      = st_q.rvld ? dec_data : '0;
    assign err_corr   = st_q.rvld && dec_corr;
    assign err_uncorr = st_q.rvld && dec_uncorr;

endmodule

// File: rtl/secded_ram_chk.sv
module secded_ram_chk (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic we,
    input logic busy,
    input logic rvalid,
    input logic err_corr,
    input logic err_uncorr
);
    a_r10_read_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !we && !busy) |=> rvalid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && !we && !busy) |=> !rvalid);

    a_r9_busy_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rvalid);

    a_r8_busy_stays_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);

    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_corr && err_uncorr));

    a_r1_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> !(err_corr || err_uncorr));
endmodule

bind secded_ram secded_ram_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .we         (we),
    .busy       (busy),
    .rvalid     (rvalid),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr)
);

// File: tb/secded_ram_tb.sv
module secded_ram_tb;
    localparam int DW    = 32;
    localparam int AW    = 10;
    localparam int CWW   = DW + 7;
    localparam int DEPTH = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req = 1'b0;
    logic           we = 1'b0;
    logic [AW-1:0]  addr = '0;
    logic [DW-1:0]  wdata = '0;
    logic [CWW-1:0] inj_mask = '0;
    logic           busy, rvalid, err_corr, err_uncorr;
    logic [DW-1:0]  rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    secded_ram u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .inj_mask(inj_mask), .busy(busy), .rvalid(rvalid),
        .rdata(rdata), .err_corr(err_corr), .err_uncorr(err_uncorr)
    );

    // Column list as stated in R2
    function automatic logic [6:0] col(input int k);
        int n = 0;
        logic [6:0] r = '0;
        for (int w = 3; w <= 7; w += 2)
            for (int v = 0; v < 128; v++)
                if ($countones(7'(v)) == w) begin
                    if (n == k) r = 7'(v);
                    n++;
                end
        return r;
    endfunction

    task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [CWW-1:0] m);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; inj_mask = m;
        @(posedge clk); @(negedge clk);
        req = 1'b0; we = 1'b0; inj_mask = '0;
        check("R10 no rvalid after write", 64'(rvalid), 64'd0);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic ce, output logic ue);
        req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk); @(negedge clk);
        req = 1'b0;
        check("R10 rvalid after read", 64'(rvalid), 64'd1);
        d = rdata; ce = err_corr; ue = err_uncorr;
        @(negedge clk);
        check("R1 outputs zero without rvalid", {rdata, err_corr, err_uncorr, rvalid}, 64'd0);
    endtask

    task automatic t_reset_init();
        int n;
        logic [DW-1:0] d; logic ce, ue;
        repeat (3) @(negedge clk);
        check("R8 busy in reset", 64'(busy), 64'd1);
        check("R10 rvalid low in reset", 64'(rvalid), 64'd0);
        rst_n = 1'b1;
        n = 0;
        while (busy && n < 5000) begin
            req = 1'b0; we = 1'b0;
            if (n == 5)   begin req = 1'b1; addr = 10'd7; end
            if (n == 200) begin req = 1'b1; we = 1'b1; addr = 10'd2; wdata = 32'hDEADBEEF; end
            @(posedge clk); @(negedge clk);
            n++;
            if (n == 6) check("R9 read while busy ignored", 64'(rvalid), 64'd0);
        end
        req = 1'b0; we = 1'b0;
        check("R8 busy length", 64'(n), 64'(DEPTH));
        rd(10'd2, d, ce, ue);
        check("R9 write while busy dropped", {d, ce, ue}, 64'd0);
        rd(10'd0, d, ce, ue);
        check("R8 row 0 zero", {d, ce, ue}, 64'd0);
        rd(10'd1023, d, ce, ue);
        check("R8 last row zero", {d, ce, ue}, 64'd0);
        rd(10'd511, d, ce, ue);
        check("R8 mid row zero", {d, ce, ue}, 64'd0);
        @(posedge clk); @(negedge clk);
        check("R8 busy stays low", 64'(busy), 64'd0);
    endtask

    task automatic t_basic();
        logic [DW-1:0] d; logic ce, ue;
        wr(10'd3, 32'hA5A5_0F0F, '0);
        wr(10'd1000, 32'hFFFF_FFFF, '0);
        wr(10'd4, 32'h0000_0001, '0);
        rd(10'd3, d, ce, ue);
        check("R1 pattern A", {d, ce, ue}, {32'hA5A5_0F0F, 2'b00});
        rd(10'd1000, d, ce, ue);
        check("R1 all ones", {d, ce, ue}, {32'hFFFF_FFFF, 2'b00});
        rd(10'd4, d, ce, ue);
        check("R1 single one", {d, ce, ue}, {32'h1, 2'b00});
    endtask

    task automatic t_single();
        logic [DW-1:0] d; logic ce, ue;
        for (int b = 0; b < DW; b += 7) begin
            wr(10'd20, 32'h1234_5678, CWW'(1) << b);
            rd(10'd20, d, ce, ue);
            check("R3 R11 data bit corrected", {d, ce, ue}, {32'h1234_5678, 2'b10});
        end
        for (int b = 0; b < 7; b += 3) begin
            wr(10'd21, 32'hCAFE_F00D, CWW'(1) << (DW + b));
            rd(10'd21, d, ce, ue);
            check("R4 check bit corrected", {d, ce, ue}, {32'hCAFE_F00D, 2'b10});
        end
    endtask

    task automatic t_double();
        logic [DW-1:0] d; logic ce, ue;
        wr(10'd30, 32'h0F0F_0F0F, (CWW'(1) << 0) | (CWW'(1) << 31));
        rd(10'd30, d, ce, ue);
        check("R5 two data bits", {ce, ue}, 64'b01);
        wr(10'd31, 32'h0F0F_0F0F, (CWW'(1) << 5) | (CWW'(1) << (DW + 2)));
        rd(10'd31, d, ce, ue);
        check("R5 data plus check bit", {ce, ue}, 64'b01);
    endtask

    task automatic t_addr_fold();
        logic [DW-1:0] d; logic ce, ue;
        logic [6:0] m;
        // Encode as if for address 13 while storing at 12: difference is column of addr bit 0
        m = col(DW + 0);
        wr(10'd12, 32'h7777_1111, {m, 32'h0});
        rd(10'd12, d, ce, ue);
        check("R6 misaddressed row uncorrectable", {ce, ue}, 64'b01);
        m = col(DW + 9);
        wr(10'd600, 32'h0, {m, 32'h0});
        rd(10'd600, d, ce, ue);
        check("R6 address high bit column", {ce, ue}, 64'b01);
    endtask

    task automatic t_no_writeback();
        logic [DW-1:0] d; logic ce, ue;
        wr(10'd40, 32'h8000_0000, CWW'(1) << 4);
        rd(10'd40, d, ce, ue);
        check("R7 first read corrected", {d, ce, ue}, {32'h8000_0000, 2'b10});
        rd(10'd40, d, ce, ue);
        check("R7 error persists", {d, ce, ue}, {32'h8000_0000, 2'b10});
        wr(10'd41, 32'h1, (CWW'(1) << 1) | (CWW'(1) << 2));
        rd(10'd41, d, ce, ue);
        rd(10'd41, d, ce, ue);
        check("R7 uncorrectable persists", {ce, ue}, 64'b01);
    endtask

    initial begin
        fork
            begin
                t_reset_init();
                t_basic();
                t_single();
                t_double();
                t_addr_fold();
                t_no_writeback();
                done = 1'b1;
            end
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                end
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule